// File: doc/BRIEF.md
# Receive Holding Buffer with Error Reporting Modes

This block is a three-deep holding buffer placed between a serial receiver and a processor read port. Each time the receiver finishes a character it strobes the character in together with three flags: parity error, framing error and break seen. The processor sees the oldest character on the read data output. A read strobe removes that character and its flags from the buffer.

The block reports two occupancy bits: one says data is waiting and one says the buffer is full. It also reports four error bits. A mode input selects how the three per-character flags are shown. In per-character mode they belong to the character now at the head. In accumulate mode they collect every flag seen at the head since the last clear command. The overrun bit is kept apart from the entries. It is set when a character arrives and there is no room for it, and it stays set until the clear command.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the buffer is empty: `rdy`, `full`, `perr`, `ferr`, `brk` and `ovr` are 0 and `rd_data` is 0.
- R2: `rdy` is 1 whenever one or more characters are held. `full` is 1 exactly when all DEPTH (3) positions are held.
- R3: Characters leave in the order they arrived. `rd_data` shows the oldest held character. A cycle with `rd_en` high and the buffer not empty removes that character at the clock edge.
- R4: With `blk_mode` = 0, the outputs `perr`, `ferr` and `brk` equal the flags stored with the head character, and all three are 0 when the buffer is empty. `blk_mode` acts on these outputs at once, with no clock delay.
- R5: With `blk_mode` = 1, each of `perr`, `ferr` and `brk` is the OR of that flag over every character that has been at the head during some clock edge since the last clear, plus the current head character.
- R6: A cycle with `clr_err` high empties the accumulated flags and clears `ovr` at the next edge. The clear wins over a set in the same cycle.
- R7: When `wr_en` is high, the buffer is full and `rd_en` is low, `ovr` is set and the incoming character is dropped. The held characters and their flags stay as they were.
- R8: When `wr_en` and `rd_en` are both high while the buffer is full, the head is removed and the new character is stored. `ovr` is not set and `full` stays 1.
- R9: A read while the buffer is empty does not change occupancy. `rd_data` keeps showing the last character removed (0 if none has been removed since reset).
- R10: `ovr` is shown in both modes. It stays 1 from the edge that sets it until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | DW (8) | Received character |
| wr_perr | input | 1 | Parity error flag for the character |
| wr_ferr | input | 1 | Framing error flag for the character |
| wr_brk | input | 1 | Break flag for the character |
| rd_en | input | 1 | Read strobe; removes the head entry |
| clr_err | input | 1 | Clear command for the accumulated flags and overrun |
| blk_mode | input | 1 | 0 = per-character error flags, 1 = accumulated error flags |
| rd_data | output | DW (8) | Head character, or the last character removed when empty |
| rdy | output | 1 | At least one character is held |
| full | output | 1 | All positions are held |
| perr | output | 1 | Reported parity error |
| ferr | output | 1 | Reported framing error |
| brk | output | 1 | Reported break |
| ovr | output | 1 | Overrun since the last clear |

## Verification
A strobe sampled at a clock edge shows up on `rdy`, `full`, `rd_data`, `ovr` and the accumulated flags once that edge has passed. A change on `blk_mode` shows up on the error bits within the same cycle, because that path is combinational. The bench sets each cycle's inputs after the falling edge. It then waits one time unit and compares every output with a reference queue held in the bench, which has already been advanced to the state after the previous rising edge. Only after that compare does it move the reference forward by one edge.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  input  logic          rd_en,
  input  logic          clr_err,
  input  logic          blk_mode,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          full,
  output logic          perr,
  output logic          ferr,
  output logic          brk,
  output logic          ovr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] dat_q [DEPTH];
  logic [2:0]    flg_q [DEPTH];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic [2:0]    acc_q;
  logic          ovr_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire       have    = (cnt_q != '0);
  wire       is_full = (cnt_q == CW'(DEPTH));
  wire       pop     = rd_en & have;
  wire       push    = wr_en & (~is_full | pop);
  wire [2:0] head_f  = have ? flg_q[rp_q] : 3'b000;
  wire [2:0] rep_f   = blk_mode ? (acc_q | head_f) : head_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dat_q[i] <= '0;
        flg_q[i] <= '0;
      end
      rp_q   <= '0;
      wp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (push) begin
        dat_q[wp_q] <= wr_data;
        flg_q[wp_q] <= {wr_brk, wr_ferr, wr_perr};
        wp_q        <= step(wp_q);
      end
      if (pop) begin
        last_q <= dat_q[rp_q];
        rp_q   <= step(rp_q);
      end
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      acc_q <= clr_err ? 3'b000 : (acc_q | head_f);
      ovr_q <= clr_err ? 1'b0 : (ovr_q | (wr_en & is_full & ~rd_en));
    end
  end

  assign rd_data = have ? dat_q[rp_q] : last_q;
  assign rdy     = have;
  assign full    = is_full;
  assign perr    = rep_f[0];
  assign ferr    = rep_f[1];
  assign brk     = rep_f[2];
  assign ovr     = ovr_q;
endmodule

module rx_hold_fifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          clr_err,
  input logic          blk_mode,
  input logic [DW-1:0] rd_data,
  input logic          rdy,
  input logic          full,
  input logic          perr,
  input logic          ferr,
  input logic          brk,
  input logic          ovr
);
  p_full_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rdy);

  p_char_empty_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !rdy) |-> (!perr && !ferr && !brk));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !ovr);

  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en && !clr_err) |=> ovr);

  p_overrun_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (full && $stable(rd_data)));

  p_full_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && full && !ovr && !clr_err) |=> (full && !ovr));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && rd_en && !wr_en) |=> (!rdy && $stable(rd_data)));

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err) |=> ovr);
endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(.DW(DW)) u_chk (.*);

// File: tb/rx_hold_fifo_test.sv
`timescale 1ns/1ps
module rx_hold_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 0, clr_err = 0, blk_mode = 0;
  logic [7:0] rd_data;
  logic       rdy, full, perr, ferr, brk, ovr;

  int tests = 0;
  int fails = 0;

  logic [7:0] qd [3];
  logic [2:0] qf [3];
  int         qn = 0;
  logic [7:0] lastd = '0;
  logic [2:0] acc = '0;
  logic       m_ovr = 1'b0;

  always #4 clk = ~clk;

  rx_hold_fifo uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rd_en(rd_en), .clr_err(clr_err), .blk_mode(blk_mode),
    .rd_data(rd_data), .rdy(rdy), .full(full), .perr(perr),
    .ferr(ferr), .brk(brk), .ovr(ovr)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [2:0] head_flags();
    return (qn > 0) ? qf[0] : 3'b000;
  endfunction

  function automatic logic [2:0] exp_flags(logic m);
    return m ? (acc | head_flags()) : head_flags();
  endfunction

  // One clock cycle: drive inputs, compare outputs with the reference, then advance it
  task automatic cyc(logic w, logic [7:0] d, logic [2:0] f, logic r, logic c, logic m, string tag);
    logic [2:0] ef;
    bit pop, push;
    wr_en = w; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
    rd_en = r; clr_err = c; blk_mode = m;
    #1;
    ef = exp_flags(m);
    check({tag, " R2 rdy"},  {7'd0, rdy},  {7'd0, qn > 0});
    check({tag, " R2 full"}, {7'd0, full}, {7'd0, qn == 3});
    check({tag, (qn > 0) ? " R3 data" : " R9 data"}, rd_data, (qn > 0) ? qd[0] : lastd);
    check({tag, m ? " R5 flags" : " R4 flags"}, {5'd0, brk, ferr, perr}, {5'd0, ef});
    check({tag, " R10 ovr"}, {7'd0, ovr}, {7'd0, m_ovr});
    @(posedge clk);
    pop  = r && qn > 0;
    push = w && (qn < 3 || pop);
    acc   = c ? 3'b000 : (acc | head_flags());
    m_ovr = c ? 1'b0 : (m_ovr | (w && qn == 3 && !r));
    if (pop) begin
      lastd = qd[0];
      qd[0] = qd[1]; qf[0] = qf[1];
      qd[1] = qd[2]; qf[1] = qf[2];
      qn--;
    end
    if (push) begin
      qd[qn] = d; qf[qn] = f; qn++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 rdy",  {7'd0, rdy},  8'd0);
    check("R1 data", rd_data, 8'd0);
    check("R1 err",  {4'd0, ovr, brk, ferr, perr}, 8'd0);
    // R9: empty read before any data
    cyc(0, 8'h00, 3'b000, 1, 0, 0, "empty");
    // fill three entries with distinct flags (R2, R3, R4)
    cyc(1, 8'hA1, 3'b001, 0, 0, 0, "fill");
    cyc(1, 8'hB2, 3'b010, 0, 0, 0, "fill");
    cyc(1, 8'hC3, 3'b100, 0, 0, 0, "fill");
    // R7: write while full is dropped and sets overrun
    cyc(1, 8'hD4, 3'b111, 0, 0, 0, "ovr");
    cyc(0, 8'h00, 3'b000, 0, 0, 1, "hold");
    // R8: read and write together while full
    cyc(1, 8'hE5, 3'b000, 1, 0, 1, "swap");
    // R6: clear drops overrun and the accumulated flags
    cyc(0, 8'h00, 3'b000, 0, 1, 1, "clr");
    // R5: drain in accumulate mode
    cyc(0, 8'h00, 3'b000, 1, 0, 1, "drain");
    cyc(0, 8'h00, 3'b000, 1, 0, 1, "drain");
    cyc(0, 8'h00, 3'b000, 1, 0, 1, "drain");
    // R9: reads on an empty buffer keep the last value
    cyc(0, 8'h00, 3'b000, 1, 0, 1, "empty");
    cyc(0, 8'h00, 3'b000, 1, 0, 0, "empty");
    // R6: overrun set and clear in the same cycle, clear wins
    cyc(1, 8'h11, 3'b000, 0, 0, 0, "fill");
    cyc(1, 8'h22, 3'b000, 0, 0, 0, "fill");
    cyc(1, 8'h33, 3'b000, 0, 0, 0, "fill");
    cyc(1, 8'h44, 3'b011, 0, 1, 0, "setclr");
    cyc(0, 8'h00, 3'b000, 0, 0, 0, "after");
    for (int i = 0; i < 4000; i++) begin
      logic w, r, c, m;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 45;
      c = ($urandom % 100) < 6;
      m = ($urandom % 100) < 50;
      cyc(w, 8'($urandom), 3'($urandom), r, c, m, "rand");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule